// File: doc/BRIEF.md
# Host Interrupt Controller with Mask Aliases

This block gathers up to sixteen interrupt sources from inside a device and hands them to a host processor through a small register window. Each source is edge-detected: a low-to-high transition latches a sticky status bit. The host picks which latched bits may reach its interrupt pin through a mask register. The mask can be written whole, or changed bit by bit through two write-only aliases that set or clear only the bits written as 1. A read-modify-write race between agents is therefore avoided.

The latched status can be read two ways. A peek view leaves it intact. A take view returns it and clears every bit in the same access. A write-one-to-acknowledge register clears selected bits, and both views see the result. A single host pin is driven from a flop. A configuration register enables the pin and picks its polarity.

The register port is a plain 32-bit word port with an address, a read strobe and a write strobe. Read data is combinational while the read strobe is high. A read or write takes effect at the rising clock edge on which its strobe is sampled. Word addresses: 0 mask, 1 mask-set alias, 2 mask-clear alias, 3 status peek, 4 status take, 5 acknowledge, 6 configuration.

Top module: `hic_top`

## Requirements
- R1: After reset, the mask (address 0) reads 0x0001, both status views read 0, configuration (address 6) reads 0 and the host pin is low.
- R2: A write to address 0 replaces all 16 mask bits with write data bits 15:0. A 1 in the mask blocks that status bit from the host pin.
- R3: A write to the set alias (address 1) sets each mask bit written as 1. Mask bits written as 0 keep their value.
- R4: A write to the clear alias (address 2) clears each mask bit written as 1. Mask bits written as 0 keep their value.
- R5: A rising edge on a source latches its status bit at that clock edge. A source that stays high does not latch again once cleared. Status bits 11, 12, 13 and 15 are never set. The used bits are 0 to 10 and 14.
- R6: A read of the peek view (address 3) returns the latched status and leaves it unchanged.
- R7: A read of the take view (address 4) returns the latched status and clears all of it at that clock edge.
- R8: A write to the acknowledge register (address 5) clears each status bit written as 1, as seen by both views. Bits written as 0 are not affected.
- R9: If a new source edge and a clear (acknowledge or take read) hit the same status bit in the same cycle, the bit ends up set.
- R10: The pin is active when configuration bit 5 is set and some status bit has a mask bit of 0. Configuration bit 7 makes the pin active-low, and a disabled pin sits at its inactive level. The pin reflects a status, mask or configuration change one clock after that change is registered.
- R11: Reads of addresses 1, 2 and 5 return 0. Data bits above 15 always read 0, and in configuration only bits 5 and 7 read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Interrupt sources, rising-edge sensitive |
| bus_addr | input | ADDR_W | Register word address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid while bus_rd is high |
| host_irq_o | output | 1 | Registered host interrupt pin |

## Verification
The bench sweeps every source bit and checks that each one lands in its own status bit, and that the unused bits never appear. A wrong bit map or a missing filter would show up as a stray bit in the peek view. It fires a source edge in the same cycle as a take read, and again with an acknowledge. A design that lets the clear win would lose that interrupt for good. It checks that zeros written to the aliases and the acknowledge register leave other bits alone, which catches a design that treats the aliases as plain writes. It samples the pin on both cycles after a change, which catches a pin that responds a cycle early or a cycle late, or that ignores the polarity bit.

// File: rtl/hic_pkg.sv
package hic_pkg;

   typedef enum logic [2:0] {
      HIC_A_MASK = 3'd0,
      HIC_A_MSET = 3'd1,
      HIC_A_MCLR = 3'd2,
      HIC_A_PEEK = 3'd3,
      HIC_A_TAKE = 3'd4,
      HIC_A_ACK  = 3'd5,
      HIC_A_CFG  = 3'd6
   } hic_addr_e;

   // source positions in the status word
   localparam int HIC_SRC_RXB0   = 0;
   localparam int HIC_SRC_TXDATA = 1;
   localparam int HIC_SRC_TXXFER = 2;
   localparam int HIC_SRC_RXB1   = 3;
   localparam int HIC_SRC_RXXFER = 4;
   localparam int HIC_SRC_EVT_A  = 5;
   localparam int HIC_SRC_EVT_B  = 6;
   localparam int HIC_SRC_WAKE   = 7;
   localparam int HIC_SRC_TRC_A  = 8;
   localparam int HIC_SRC_TRC_B  = 9;
   localparam int HIC_SRC_CMDDN  = 10;
   localparam int HIC_SRC_INITDN = 14;

   localparam logic [15:0] HIC_USED_DEFAULT =
      (16'h1 << HIC_SRC_RXB0)   | (16'h1 << HIC_SRC_TXDATA) |
      (16'h1 << HIC_SRC_TXXFER) | (16'h1 << HIC_SRC_RXB1)   |
      (16'h1 << HIC_SRC_RXXFER) | (16'h1 << HIC_SRC_EVT_A)  |
      (16'h1 << HIC_SRC_EVT_B)  | (16'h1 << HIC_SRC_WAKE)   |
      (16'h1 << HIC_SRC_TRC_A)  | (16'h1 << HIC_SRC_TRC_B)  |
      (16'h1 << HIC_SRC_CMDDN)  | (16'h1 << HIC_SRC_INITDN);

   localparam int HIC_CFG_EN_BIT  = 5;
   localparam int HIC_CFG_LOW_BIT = 7;

endpackage

// File: rtl/hic_edge_detect.sv
module hic_edge_detect #(
   parameter int N = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] src_i,
   output logic [N-1:0] rise_o
);

   logic [N-1:0] prev_q;

   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev_q[i] <= 1'b0;
         else        prev_q[i] <= src_i[i];
      end
      assign rise_o[i] = src_i[i] & ~prev_q[i];
   end

endmodule

// File: rtl/hic_status.sv
module hic_status #(
   parameter int         N    = 16,
   parameter logic [N-1:0] USED = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] rise_i,
   input  logic [N-1:0] ack_i,
   input  logic         take_i,
   output logic [N-1:0] status_o
);

   for (genvar i = 0; i < N; i++) begin : g_bit
      logic st_q;
      logic keep;
      assign keep = st_q & ~ack_i[i] & ~take_i;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) st_q <= 1'b0;
         else        st_q <= (rise_i[i] & USED[i]) | keep;
      end
      assign status_o[i] = st_q;
   end

endmodule

// File: rtl/hic_mask_reg.sv
module hic_mask_reg #(
   parameter int           N     = 16,
   parameter logic [N-1:0] RESET = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_all_i,
   input  logic         wr_set_i,
   input  logic         wr_clr_i,
   input  logic [N-1:0] wdata_i,
   output logic [N-1:0] mask_o
);

   logic [N-1:0] mask_q;
   logic [N-1:0] mask_d;

   always_comb begin
      mask_d = mask_q;
      if (wr_all_i)      mask_d = wdata_i;
      else if (wr_set_i) mask_d = mask_q | wdata_i;
      else if (wr_clr_i) mask_d = mask_q & ~wdata_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q <= RESET;
      else        mask_q <= mask_d;
   end

   assign mask_o = mask_q;

endmodule

// File: rtl/hic_pin_drive.sv
module hic_pin_drive #(
   parameter int N = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] status_i,
   input  logic [N-1:0] mask_i,
   input  logic         en_i,
   input  logic         low_i,
   output logic         irq_o
);

   logic pending;
   logic irq_q;

   assign pending = |(status_i & ~mask_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= (en_i & pending) ^ low_i;
   end

   assign irq_o = irq_q;

endmodule

// File: rtl/hic_top.sv
module hic_top
   import hic_pkg::*;
#(
   parameter int           NUM_SRC    = 16,
   parameter int           ADDR_W     = 4,
   parameter int           DATA_W     = 32,
   parameter logic [15:0]  MASK_RESET = 16'h0001,
   parameter logic [15:0]  USED_BITS  = HIC_USED_DEFAULT
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_rd,
   input  logic               bus_wr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic               host_irq_o
);

   localparam logic [NUM_SRC-1:0] USED_N  = USED_BITS[NUM_SRC-1:0];
   localparam logic [NUM_SRC-1:0] RESET_N = MASK_RESET[NUM_SRC-1:0];

   if (NUM_SRC < 1 || NUM_SRC > 16) begin : g_bad_nsrc
      $error("hic_top: NUM_SRC must lie in 1..16");
   end
   if (DATA_W < 16) begin : g_bad_dw
      $error("hic_top: DATA_W must be at least 16");
   end
   if (ADDR_W < 3) begin : g_bad_aw
      $error("hic_top: ADDR_W must be at least 3");
   end

   logic sel_mask, sel_mset, sel_mclr, sel_peek, sel_take, sel_ack, sel_cfg;
   assign sel_mask = (bus_addr == ADDR_W'(HIC_A_MASK));
   assign sel_mset = (bus_addr == ADDR_W'(HIC_A_MSET));
   assign sel_mclr = (bus_addr == ADDR_W'(HIC_A_MCLR));
   assign sel_peek = (bus_addr == ADDR_W'(HIC_A_PEEK));
   assign sel_take = (bus_addr == ADDR_W'(HIC_A_TAKE));
   assign sel_ack  = (bus_addr == ADDR_W'(HIC_A_ACK));
   assign sel_cfg  = (bus_addr == ADDR_W'(HIC_A_CFG));

   logic [NUM_SRC-1:0] wd_n;
   assign wd_n = bus_wdata[NUM_SRC-1:0];
   logic unused_wdata;
   assign unused_wdata = ^bus_wdata;

   logic [NUM_SRC-1:0] rise;
   logic [NUM_SRC-1:0] status;
   logic [NUM_SRC-1:0] mask;
   logic [NUM_SRC-1:0] ack_bits;
   logic               take;

   assign ack_bits = (bus_wr && sel_ack) ? wd_n : '0;
   assign take     = bus_rd && sel_take;

   hic_edge_detect #(.N(NUM_SRC)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .src_i  (src_i),
      .rise_o (rise)
   );

   hic_status #(.N(NUM_SRC), .USED(USED_N)) u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .rise_i   (rise),
      .ack_i    (ack_bits),
      .take_i   (take),
      .status_o (status)
   );

   hic_mask_reg #(.N(NUM_SRC), .RESET(RESET_N)) u_mask (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_all_i (bus_wr && sel_mask),
      .wr_set_i (bus_wr && sel_mset),
      .wr_clr_i (bus_wr && sel_mclr),
      .wdata_i  (wd_n),
      .mask_o   (mask)
   );

   logic cfg_en_q, cfg_low_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_en_q  <= 1'b0;
         cfg_low_q <= 1'b0;
      end else if (bus_wr && sel_cfg) begin
         cfg_en_q  <= bus_wdata[HIC_CFG_EN_BIT];
         cfg_low_q <= bus_wdata[HIC_CFG_LOW_BIT];
      end
   end

   hic_pin_drive #(.N(NUM_SRC)) u_pin (
      .clk      (clk),
      .rst_n    (rst_n),
      .status_i (status),
      .mask_i   (mask),
      .en_i     (cfg_en_q),
      .low_i    (cfg_low_q),
      .irq_o    (host_irq_o)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         if (sel_mask)                 bus_rdata = DATA_W'(mask);
         else if (sel_peek || sel_take) bus_rdata = DATA_W'(status);
         else if (sel_cfg) begin
            bus_rdata[HIC_CFG_EN_BIT]  = cfg_en_q;
            bus_rdata[HIC_CFG_LOW_BIT] = cfg_low_q;
         end
      end
   end

endmodule

// File: rtl/hic_checker.sv
module hic_checker
   import hic_pkg::*;
#(
   parameter int           NUM_SRC   = 16,
   parameter int           ADDR_W    = 4,
   parameter int           DATA_W    = 32,
   parameter logic [15:0]  USED_BITS = HIC_USED_DEFAULT
) (
   input logic               clk,
   input logic               rst_n,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic               bus_rd,
   input logic               bus_wr,
   input logic [DATA_W-1:0]  bus_wdata,
   input logic [DATA_W-1:0]  bus_rdata,
   input logic               host_irq_o,
   input logic [NUM_SRC-1:0] rise,
   input logic [NUM_SRC-1:0] status,
   input logic [NUM_SRC-1:0] mask,
   input logic               cfg_en_q,
   input logic               cfg_low_q
);

   localparam logic [NUM_SRC-1:0] USED_N = USED_BITS[NUM_SRC-1:0];

   logic [NUM_SRC-1:0] wd;
   assign wd = bus_wdata[NUM_SRC-1:0];

   AST_MSET_ONLY_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(HIC_A_MSET)) |=>
      (mask == ($past(mask) | $past(wd)))); // R3

   AST_MCLR_ONLY_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(HIC_A_MCLR)) |=>
      (mask == ($past(mask) & ~$past(wd)))); // R4

   AST_PEEK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_wr && bus_addr == ADDR_W'(HIC_A_PEEK)) |=>
      (status == ($past(status) | ($past(rise) & USED_N)))); // R6

   AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_wr && bus_addr == ADDR_W'(HIC_A_TAKE)) |=>
      (status == ($past(rise) & USED_N))); // R7

   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !bus_rd && bus_addr == ADDR_W'(HIC_A_ACK)) |=>
      (status == (($past(status) & ~$past(wd)) | ($past(rise) & USED_N)))); // R8

   AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (|(rise & USED_N)) |=> ((status & $past(rise & USED_N)) == $past(rise & USED_N))); // R9

   AST_UNUSED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && (bus_addr == ADDR_W'(HIC_A_PEEK) || bus_addr == ADDR_W'(HIC_A_TAKE))) |->
      ((bus_rdata & ~DATA_W'(USED_N)) == '0)); // R5

   AST_PIN_ONE_LATE: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (host_irq_o == (($past(cfg_en_q) && (|($past(status) & ~$past(mask))))
                                ^ $past(cfg_low_q)))); // R10

   AST_ALIAS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && (bus_addr == ADDR_W'(HIC_A_MSET) || bus_addr == ADDR_W'(HIC_A_MCLR) ||
                  bus_addr == ADDR_W'(HIC_A_ACK))) |-> (bus_rdata == '0)); // R11

endmodule

bind hic_top hic_checker #(
   .NUM_SRC  (NUM_SRC),
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .USED_BITS(USED_BITS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_addr   (bus_addr),
   .bus_rd     (bus_rd),
   .bus_wr     (bus_wr),
   .bus_wdata  (bus_wdata),
   .bus_rdata  (bus_rdata),
   .host_irq_o (host_irq_o),
   .rise       (rise),
   .status     (status),
   .mask       (mask),
   .cfg_en_q   (cfg_en_q),
   .cfg_low_q  (cfg_low_q)
);

// File: tb/sim_hic_top.sv
module sim_hic_top;

   localparam int          CLK_PERIOD = 10;
   localparam logic [15:0] USED       = 16'h47FF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] src_i = '0;
   logic [3:0]  bus_addr = '0;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        host_irq_o;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hic_top u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .src_i      (src_i),
      .bus_addr   (bus_addr),
      .bus_rd     (bus_rd),
      .bus_wr     (bus_wr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .host_irq_o (host_irq_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   // all tasks start and end just after a falling edge
   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic pulse(input logic [15:0] bits);
      src_i = bits;
      @(negedge clk);
      src_i = '0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      logic [31:0] v2;
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state
      rd(4'd0, v); chk("R1 mask reset", v, 32'h1);
      rd(4'd3, v); chk("R1 peek reset", v, 32'h0);
      rd(4'd6, v); chk("R1 cfg reset", v, 32'h0);
      chk("R1 pin reset", {31'd0, host_irq_o}, 32'h0);

      // R2 direct mask write, upper bits discarded (R11)
      wr(4'd0, 32'hFFFF_A5A5);
      rd(4'd0, v); chk("R2 direct mask write", v, 32'h0000_A5A5);
      wr(4'd0, 32'h0000_3C00);
      rd(4'd0, v); chk("R2 direct mask replace", v, 32'h0000_3C00);

      // R3 set alias
      wr(4'd0, 32'h0);
      wr(4'd1, 32'h0101);
      rd(4'd0, v); chk("R3 set alias", v, 32'h0101);
      wr(4'd1, 32'h0010);
      rd(4'd0, v); chk("R3 set alias zeros keep", v, 32'h0111);

      // R4 clear alias
      wr(4'd2, 32'h0100);
      rd(4'd0, v); chk("R4 clear alias", v, 32'h0011);
      wr(4'd2, 32'h0000);
      rd(4'd0, v); chk("R4 clear alias zeros keep", v, 32'h0011);

      // R11 write-only registers read zero
      rd(4'd1, v); chk("R11 set alias reads 0", v, 32'h0);
      rd(4'd2, v); chk("R11 clear alias reads 0", v, 32'h0);
      rd(4'd5, v); chk("R11 ack reads 0", v, 32'h0);
      wr(4'd6, 32'hFFFF_FFFF);
      rd(4'd6, v); chk("R11 cfg readback bits 5,7", v, 32'h0000_00A0);
      wr(4'd6, 32'h0);

      // R5/R7 sweep over every source bit
      wr(4'd0, 32'hFFFF);
      wr(4'd5, 32'hFFFF);
      for (int b = 0; b < 16; b++) begin
         logic [31:0] e;
         e = {16'd0, (16'h1 << b) & USED};
         pulse(16'h1 << b);
         rd(4'd3, v);  chk($sformatf("R5 latch bit %0d", b), v, e);
         rd(4'd4, v2); chk($sformatf("R7 take bit %0d", b), v2, e);
         rd(4'd3, v);  chk($sformatf("R7 cleared after take bit %0d", b), v, 32'h0);
      end

      // R5 held source does not relatch
      src_i = 16'h0002;
      idle(1);
      wr(4'd5, 32'h0002);
      idle(2);
      rd(4'd3, v); chk("R5 held source no relatch", v, 32'h0);
      src_i = '0;
      idle(1);

      // R6 peek keeps
      pulse(16'h0005);
      rd(4'd3, v); chk("R6 peek first", v, 32'h0005);
      rd(4'd3, v); chk("R6 peek second", v, 32'h0005);

      // R8 acknowledge, both views
      wr(4'd5, 32'h0001);
      rd(4'd3, v); chk("R8 ack peek view", v, 32'h0004);
      rd(4'd4, v); chk("R8 ack take view", v, 32'h0004);
      pulse(16'h0400);
      wr(4'd5, 32'h0000);
      rd(4'd3, v); chk("R8 ack zeros no effect", v, 32'h0400);
      wr(4'd5, 32'hFFFF);

      // R9 event versus take in same cycle
      src_i = 16'h0008;
      rd(4'd4, v); chk("R9 take returns old", v, 32'h0);
      rd(4'd3, v); chk("R9 event beats take", v, 32'h0008);
      src_i = '0;
      idle(1);
      // R9 event versus acknowledge in same cycle
      src_i = 16'h0008;
      wr(4'd5, 32'h0008);
      rd(4'd3, v); chk("R9 event beats ack", v, 32'h0008);
      src_i = '0;
      wr(4'd5, 32'hFFFF);

      // R10 pin behaviour
      wr(4'd0, 32'h0);
      idle(2);
      pulse(16'h0001);
      idle(2);
      chk("R10 pin disabled", {31'd0, host_irq_o}, 32'h0);
      wr(4'd6, 32'h20);
      chk("R10 pin not yet enabled", {31'd0, host_irq_o}, 32'h0);
      idle(1);
      chk("R10 pin asserted one late", {31'd0, host_irq_o}, 32'h1);
      wr(4'd1, 32'h0001);
      chk("R10 pin before mask takes", {31'd0, host_irq_o}, 32'h1);
      idle(1);
      chk("R10 pin masked", {31'd0, host_irq_o}, 32'h0);
      wr(4'd6, 32'hA0);
      idle(1);
      chk("R10 active-low idle high", {31'd0, host_irq_o}, 32'h1);
      wr(4'd2, 32'h0001);
      idle(1);
      chk("R10 active-low asserted", {31'd0, host_irq_o}, 32'h0);
      wr(4'd5, 32'h0001);
      idle(1);
      chk("R10 active-low after ack", {31'd0, host_irq_o}, 32'h1);
      wr(4'd6, 32'h80);
      pulse(16'h0002);
      idle(2);
      chk("R10 disabled low-polarity inactive", {31'd0, host_irq_o}, 32'h1);

      finish_run();
   end

endmodule